// File: doc/BRIEF.md
# Peripheral Interrupt Flag Register

This block gathers interrupt requests from eight peripheral sources into one 8-bit flag register and turns them into a single interrupt request line. Six of the bits are sticky. A one-cycle event pulse from a peripheral sets its bit, and the bit stays set until software writes it back to 0. The remaining two bits are not stored. They mirror the live state of a serial receive buffer (holding data) and a serial transmit buffer (empty). Each one drops in the same cycle that software reads the receive data or writes the transmit data.

A per-bit enable mask and a global enable bit live next to the flags. A flag is recorded whether or not it is enabled. The interrupt request is the registered OR of every enabled, set flag, qualified by the global enable. Software reaches the flag, enable and control registers through a single-cycle strobed port with a 2-bit select. A parameter removes the top flag for cut-down variants of the chip.

Top module: `periph_irq_flags`

## Requirements
- R1: The flag bits are ordered, from bit 7 down to bit 0: parallel-port access, conversion done, receive data ready, transmit buffer empty, synchronous transfer done, capture/compare, timer-2 period match, timer-1 overflow. An event pulse sets its sticky bit on the next clock edge whatever the enable mask and global enable hold.
- R2: A set sticky bit (7, 6, 3, 2, 1, 0) stays set until a write of 0 to that bit in the flag register (select 0).
- R3: When an event and a clearing write reach the same sticky bit in the same cycle, the bit ends up set.
- R4: Writing 1 to a sticky bit in the flag register sets it.
- R5: Bit 5 equals the receive-buffer-full level, except that it reads 0 in any cycle where the receive-data read strobe is high. Writes to bit 5 have no effect.
- R6: Bit 4 equals the transmit-buffer-empty level, except that it reads 0 in any cycle where the transmit-data write strobe is high. Writes to bit 4 have no effect.
- R7: After synchronous reset, the sticky flags, the enable mask, the global enable and the interrupt request are all 0.
- R8: The capture/compare bit is set as follows, depending on the 2-bit mode input. With mode 00 (capture) it is set by the capture event only. With mode 01 (compare) it is set by the compare event only. With modes 10 and 11 (PWM) neither event sets it.
- R9: The interrupt request is high one cycle after a cycle in which the global enable is 1 and at least one bit has both its flag and its enable bit set. Otherwise it is low.
- R10: When the parallel-port parameter is 0, bit 7 always reads 0 and ignores both its event and writes.
- R11: The register select chooses the flags (0), the 8-bit enable mask (1) or the control register (2, global enable in bit 0). Read data is combinational while the read strobe is high, and reads 0 for select 3 or when the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 flags, 1 enable, 2 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| evt_pport | input | 1 | Parallel-port access event pulse |
| evt_conv | input | 1 | Conversion-done event pulse |
| evt_sync | input | 1 | Synchronous serial transfer-done pulse |
| evt_capture | input | 1 | Capture event pulse |
| evt_compare | input | 1 | Compare-match event pulse |
| ccp_mode | input | 2 | Capture/compare mode: 00 capture, 01 compare, 1x PWM |
| evt_tmr2 | input | 1 | Timer-2 period-match pulse |
| evt_tmr1 | input | 1 | Timer-1 overflow pulse |
| rx_full | input | 1 | Receive buffer holds data (level) |
| rx_rd_stb | input | 1 | Receive data register read strobe |
| tx_empty | input | 1 | Transmit buffer empty (level) |
| tx_wr_stb | input | 1 | Transmit data register write strobe |
| irq | output | 1 | Registered interrupt request |

## Verification
Assertions check several rules on every cycle: a sticky bit is set on the cycle after an event, and a clearing write without an event leaves it cleared. The PWM modes never produce a capture/compare set. The request stays low after a cycle with the global enable off or with no enabled flag set. The live receive and transmit bits read 0 while their strobes are high or their levels are low. Only the bench scenarios can show the bit ordering, the exact request value across every enable mask, the read-back of the register map, and the cut-down variant with the top bit removed.

// File: rtl/pif_pkg.sv
// Shared constants and types for the peripheral interrupt flag register.
// Assumes an 8-bit flag word whose bit order is fixed by software.
package pif_pkg;
    localparam int FLAG_W    = 8;
    localparam int SEL_W     = 2;
    localparam int BIT_PPORT = 7;
    localparam int BIT_CONV  = 6;
    localparam int BIT_RX    = 5;
    localparam int BIT_TX    = 4;
    localparam int BIT_SYNC  = 3;
    localparam int BIT_CCP   = 2;
    localparam int BIT_TMR2  = 1;
    localparam int BIT_TMR1  = 0;

    // Bits held in storage; the others mirror buffer state.
    localparam logic [FLAG_W-1:0] STICKY_MASK = 8'b1100_1111;

    typedef enum logic [SEL_W-1:0] {
        SEL_FLAGS  = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CCP_CAPTURE = 2'b00,
        CCP_COMPARE = 2'b01,
        CCP_PWM_LO  = 2'b10,
        CCP_PWM_HI  = 2'b11
    } ccp_mode_e;
endpackage

// File: rtl/pif_sticky_bit.sv
// One sticky interrupt flag. A hardware set pulse has priority over a
// software write, and a software write loads the written value.
// With PRESENT = 0 the bit is tied to 0 and its inputs are ignored.
// Assumes hw_set is a synchronous pulse in the clk domain.
module pif_sticky_bit #(
    parameter bit PRESENT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_wr,
    input  logic sw_val,
    output logic q
);
    generate
        if (PRESENT) begin : g_live
            // Flag state: event wins over the write, the write wins over hold.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= 1'b0;
                else if (hw_set)
                    q <= 1'b1;
                else if (sw_wr)
                    q <= sw_val;
            end

            assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
                hw_set |=> q);
            assert_clear_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (sw_wr && !sw_val && !hw_set) |=> !q);
            assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (!sw_wr && !hw_set && q) |=> q);
        end else begin : g_absent
            logic unused_inputs;
            assign unused_inputs = ^{clk, rst_n, hw_set, sw_wr, sw_val};
            assign q = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/pif_ccp_qual.sv
// Selects which capture/compare event may raise the capture/compare flag,
// depending on the peripheral mode. In the PWM modes neither event counts.
// Assumes the mode input is stable around the events.
module pif_ccp_qual
    import pif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       evt_capture,
    input  logic       evt_compare,
    output logic       ccp_set
);
    ccp_mode_e mode_e;
    assign mode_e = ccp_mode_e'(mode);

    // Mode decode: pass only the event that belongs to the current mode.
    always_comb begin
        case (mode_e)
            CCP_CAPTURE: ccp_set = evt_capture;
            CCP_COMPARE: ccp_set = evt_compare;
            default:     ccp_set = 1'b0;
        endcase
    end

    assert_pwm_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |-> !ccp_set);
    assert_no_cross_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_capture && !evt_compare) |-> !ccp_set);
endmodule

// File: rtl/pif_irq_gate.sv
// Combines flags with the enable mask and the global enable into one
// registered interrupt request. Assumes flags and mask share clk.
module pif_irq_gate
    import pif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] flags,
    input  logic [FLAG_W-1:0] enables,
    input  logic              global_en,
    output logic              irq
);
    logic any_pending;
    assign any_pending = |(flags & enables);

    // Request register: one cycle from flag/enable change to output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= global_en && any_pending;
    end

    assert_gie_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !global_en |=> !irq);
    assert_none_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & enables) == '0) |=> !irq);
endmodule

// File: rtl/periph_irq_flags.sv
// Peripheral interrupt flag register: six sticky event flags, two live
// buffer-status bits, an enable mask, a global enable and a registered
// interrupt request, all behind a strobed register port.
// Assumes event pulses and strobes are synchronous to clk.
module periph_irq_flags
    import pif_pkg::*;
#(
    parameter bit HAS_PPORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [FLAG_W-1:0] reg_wdata,
    output logic [FLAG_W-1:0] reg_rdata,
    input  logic              evt_pport,
    input  logic              evt_conv,
    input  logic              evt_sync,
    input  logic              evt_capture,
    input  logic              evt_compare,
    input  logic [1:0]        ccp_mode,
    input  logic              evt_tmr2,
    input  logic              evt_tmr1,
    input  logic              rx_full,
    input  logic              rx_rd_stb,
    input  logic              tx_empty,
    input  logic              tx_wr_stb,
    output logic              irq
);
    logic [FLAG_W-1:0] flag_vec;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] en_q;
    logic              gie_q;
    logic              ccp_set;
    logic              flag_wr;
    logic              rx_live;
    logic              tx_live;
    logic [FLAG_W-1:0] rd_mux;

    assign flag_wr = reg_wr && (reg_sel == SEL_FLAGS);
    assign rx_live = rx_full && !rx_rd_stb;
    assign tx_live = tx_empty && !tx_wr_stb;

    pif_ccp_qual u_ccp (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (ccp_mode),
        .evt_capture (evt_capture),
        .evt_compare (evt_compare),
        .ccp_set     (ccp_set)
    );

    // Event vector in flag-bit order; live bits take no event.
    always_comb begin
        set_vec            = '0;
        set_vec[BIT_PPORT] = evt_pport;
        set_vec[BIT_CONV]  = evt_conv;
        set_vec[BIT_SYNC]  = evt_sync;
        set_vec[BIT_CCP]   = ccp_set;
        set_vec[BIT_TMR2]  = evt_tmr2;
        set_vec[BIT_TMR1]  = evt_tmr1;
    end

    genvar gi;
    generate
        for (gi = 0; gi < FLAG_W; gi++) begin : g_flag
            if (STICKY_MASK[gi]) begin : g_sticky
                pif_sticky_bit #(
                    .PRESENT ((gi == BIT_PPORT) ? HAS_PPORT : 1'b1)
                ) u_bit (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .hw_set (set_vec[gi]),
                    .sw_wr  (flag_wr),
                    .sw_val (reg_wdata[gi]),
                    .q      (flag_vec[gi])
                );
            end else if (gi == BIT_RX) begin : g_rx
                assign flag_vec[gi] = rx_live;
            end else begin : g_tx
                assign flag_vec[gi] = tx_live;
            end
        end
    endgenerate

    // Enable mask and global enable registers, written through the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            gie_q <= 1'b0;
        end else if (reg_wr) begin
            if (reg_sel == SEL_ENABLE)
                en_q <= reg_wdata;
            if (reg_sel == SEL_CTRL)
                gie_q <= reg_wdata[0];
        end
    end

    // Read multiplexer, gated by the read strobe.
    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_FLAGS:  rd_mux = flag_vec;
            SEL_ENABLE: rd_mux = en_q;
            SEL_CTRL:   rd_mux = {{(FLAG_W-1){1'b0}}, gie_q};
            default:    rd_mux = '0;
        endcase
        reg_rdata = reg_rd ? rd_mux : '0;
    end

    pif_irq_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags     (flag_vec),
        .enables   (en_q),
        .global_en (gie_q),
        .irq       (irq)
    );

    assert_rx_strobe_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd_stb |-> !flag_vec[BIT_RX]);
    assert_rx_follows_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_full |-> !flag_vec[BIT_RX]);
    assert_tx_strobe_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_stb |-> !flag_vec[BIT_TX]);
    assert_tx_follows_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_empty |-> !flag_vec[BIT_TX]);
    assert_idle_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> (reg_rdata == '0));
endmodule

// File: tb/periph_irq_flags_tb.sv
`timescale 1ns/1ps
module periph_irq_flags_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_rd = 0, reg_wr = 0;
    logic [1:0] reg_sel = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] rdata_a, rdata_b;
    logic       evt_pport = 0, evt_conv = 0, evt_sync = 0, evt_capture = 0;
    logic       evt_compare = 0, evt_tmr2 = 0, evt_tmr1 = 0;
    logic [1:0] ccp_mode = 0;
    logic       rx_full = 0, rx_rd_stb = 0, tx_empty = 0, tx_wr_stb = 0;
    logic       irq_a, irq_b;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    periph_irq_flags #(.HAS_PPORT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(rdata_a),
        .evt_pport(evt_pport), .evt_conv(evt_conv), .evt_sync(evt_sync),
        .evt_capture(evt_capture), .evt_compare(evt_compare), .ccp_mode(ccp_mode),
        .evt_tmr2(evt_tmr2), .evt_tmr1(evt_tmr1), .rx_full(rx_full),
        .rx_rd_stb(rx_rd_stb), .tx_empty(tx_empty), .tx_wr_stb(tx_wr_stb), .irq(irq_a));

    periph_irq_flags #(.HAS_PPORT(1'b0)) u_dut_nopp (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(rdata_b),
        .evt_pport(evt_pport), .evt_conv(evt_conv), .evt_sync(evt_sync),
        .evt_capture(evt_capture), .evt_compare(evt_compare), .ccp_mode(ccp_mode),
        .evt_tmr2(evt_tmr2), .evt_tmr1(evt_tmr1), .rx_full(rx_full),
        .rx_rd_stb(rx_rd_stb), .tx_empty(tx_empty), .tx_wr_stb(tx_wr_stb), .irq(irq_b));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] a, output logic [7:0] b);
        reg_rd = 1; reg_sel = sel;
        #0.5;
        a = rdata_a; b = rdata_b;
        reg_rd = 0;
    endtask

    task automatic pulse(input int b);
        case (b)
            7: evt_pport = 1;
            6: evt_conv = 1;
            3: evt_sync = 1;
            2: evt_capture = 1;
            1: evt_tmr2 = 1;
            default: evt_tmr1 = 1;
        endcase
        @(negedge clk);
        {evt_pport, evt_conv, evt_sync, evt_capture, evt_tmr2, evt_tmr1} = '0;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] a, b;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R7: reset state
        rd(2'd0, a, b); check("R7 flags", a, 0);
        rd(2'd1, a, b); check("R7 enable", a, 0);
        rd(2'd2, a, b); check("R7 ctrl", a, 0);
        check("R7 irq", irq_a, 0);

        // R1/R2: each sticky event sets only its bit with enables off, holds, clears
        foreach (pif_pkg::STICKY_MASK[i]) begin
            if (pif_pkg::STICKY_MASK[i]) begin
                pulse(i);
                rd(2'd0, a, b); check("R1 event sets bit", a, 32'(1 << i));
                @(negedge clk); check("R1 irq off while disabled", irq_a, 0);
                repeat (3) @(negedge clk);
                rd(2'd0, a, b); check("R2 bit holds", a, 32'(1 << i));
                wr(2'd0, 8'h00);
                rd(2'd0, a, b); check("R2 write zero clears", a, 0);
            end
        end

        // R4/R5/R6: write ones sets sticky bits only
        wr(2'd0, 8'hFF);
        rd(2'd0, a, b); check("R4 R5 R6 write ones", a, 32'hCF);
        check("R10 write ignored on bit7", b, 32'h4F);
        wr(2'd0, 8'h00);

        // R3: event and clearing write collide
        wr(2'd0, 8'h40);
        evt_conv = 1; reg_wr = 1; reg_sel = 0; reg_wdata = 8'h00;
        @(negedge clk);
        evt_conv = 0; reg_wr = 0;
        rd(2'd0, a, b); check("R3 set wins", a, 32'h40);
        wr(2'd0, 8'h00);

        // R8: capture/compare mode sweep
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 2; e++) begin
                ccp_mode = 2'(m);
                if (e == 0) evt_capture = 1; else evt_compare = 1;
                @(negedge clk);
                evt_capture = 0; evt_compare = 0;
                rd(2'd0, a, b);
                check("R8 ccp mode", a, ((m == 0 && e == 0) || (m == 1 && e == 1)) ? 32'h04 : 32'h00);
                wr(2'd0, 8'h00);
            end
        end
        ccp_mode = 0;

        // R5/R6: live buffer bits
        rx_full = 1; rd(2'd0, a, b); check("R5 rx level", a, 32'h20);
        rx_rd_stb = 1; rd(2'd0, a, b); check("R5 rx read strobe", a, 32'h00);
        rx_rd_stb = 0; rx_full = 0;
        wr(2'd0, 8'h20); rd(2'd0, a, b); check("R5 write ignored", a, 32'h00);
        tx_empty = 1; rd(2'd0, a, b); check("R6 tx level", a, 32'h10);
        tx_wr_stb = 1; rd(2'd0, a, b); check("R6 tx write strobe", a, 32'h00);
        tx_wr_stb = 0; tx_empty = 0;
        wr(2'd0, 8'h10); rd(2'd0, a, b); check("R6 write ignored", a, 32'h00);

        // R10: removed top bit ignores events
        pulse(7);
        rd(2'd0, a, b); check("R10 event ignored", b, 0); check("R1 pport", a, 32'h80);
        wr(2'd1, 8'h80); wr(2'd2, 8'h01); @(negedge clk);
        check("R10 no irq", irq_b, 0); check("R9 pport irq", irq_a, 1);
        wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h00);

        // R11: register map readback
        wr(2'd1, 8'h5A); rd(2'd1, a, b); check("R11 enable readback", a, 32'h5A);
        wr(2'd2, 8'hFF); rd(2'd2, a, b); check("R11 ctrl readback", a, 32'h01);
        rd(2'd3, a, b); check("R11 unused select", a, 0);
        check("R11 idle port", rdata_a, 0);
        wr(2'd2, 8'h00); wr(2'd1, 8'h00);

        // R9: latency — flag set with enable, then gie written
        wr(2'd0, 8'h01); wr(2'd1, 8'h01);
        wr(2'd2, 8'h01); check("R9 one cycle latency", irq_a, 0);
        @(negedge clk); check("R9 asserted", irq_a, 1);
        wr(2'd2, 8'h00);

        // R9: sweep every enable mask with both global enable values
        rx_full = 1;
        wr(2'd0, 8'h85);
        for (int en = 0; en < 256; en++) begin
            for (int g = 0; g < 2; g++) begin
                wr(2'd1, 8'(en));
                wr(2'd2, 8'(g));
                @(negedge clk);
                check("R9 irq sweep", irq_a, (g == 1 && ((8'hA5 & 8'(en)) != 0)) ? 1 : 0);
            end
        end
        rx_full = 0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule